// File: doc/BRIEF.md
# Link Bus-Reset Transmit Gating Controller

This block sits in the control path of a serial-bus link layer. It watches the bus-reset indication coming from the PHY. When a reset is seen, it turns the asynchronous transmitter off and leaves the receiver alone, so the self-ID packets that follow a reset can still be collected. When the PHY reports the node's new physical ID, the block loads it into the node ID register. The transmitter stays off until software writes its enable bit again.

Software reaches the block through a simple register write port with three registers:

- **Control**, at offset 0.
- **Bus number**, at offset 1.
- **Interrupt clear**, at offset 2.

The block drives the transmit and receive enables, the composed 16-bit node ID, a flag that says the ID is valid, and a bus-reset interrupt line. All outputs are registered and change one clock after the cause.

Top module: `lnk_rst_gate`

## Requirements
- R1: After reset (`rst_n` low), the outputs are `tx_en_o`=0, `rx_en_o`=0, `irq_o`=0 and `id_vld_o`=0, and `node_id_o`=16'hFFFF.
- R2: With `bus_rst_act_i` low, a write to offset 0 loads `tx_en_o` from data bit 0 and `rx_en_o` from data bit 1. The new values appear on the following clock.
- R3: In every cycle where `bus_rst_act_i` is high, `tx_en_o` is 0 on the next clock.
- R4: `bus_rst_act_i` never changes `rx_en_o`; only a write to offset 0 does.
- R5: A write to offset 0 while `bus_rst_act_i` is high cannot set `tx_en_o`. The bit-1 (receive) part of that same write still takes effect.
- R6: Hardware never sets `tx_en_o`. It rises only on the clock after a write to offset 0, including after a bus reset has ended.
- R7: A rising edge of `bus_rst_act_i` sets `irq_o` on the next clock. A reset that stays high sets it only once.
- R8: Writing offset 2 with data bit 0 = 1 clears `irq_o`, and writing 0 there leaves it unchanged. If the clear comes in the same cycle as a reset rising edge, the set wins.
- R9: A rising edge of `bus_rst_act_i` clears `id_vld_o` on the next clock.
- R10: A `node_id_vld_i` strobe while `bus_rst_act_i` is low loads `phy_id_i` into `node_id_o[5:0]`, sets `id_vld_o`, and keeps `node_id_o[15:6]`. A strobe while `bus_rst_act_i` is high is ignored.
- R11: A write to offset 1 loads data bits [9:0] into `node_id_o[15:6]`.
- R12: A write to offset 3 changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_act_i | input | 1 | High while the PHY reports a bus reset in progress |
| node_id_vld_i | input | 1 | Strobe: `phy_id_i` carries the new physical ID |
| phy_id_i | input | 6 | Physical ID reported by the PHY |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 10 | Register write data |
| tx_en_o | output | 1 | Asynchronous transmit enable |
| rx_en_o | output | 1 | Receive enable |
| node_id_o | output | 16 | Node ID: bus number [15:6], physical ID [5:0] |
| id_vld_o | output | 1 | Node ID has been captured since the last reset |
| irq_o | output | 1 | Bus-reset interrupt flag |

## Verification
Three kinds of software write can land in the same cycle as the rising edge of a bus reset:

- a transmit-enable write;
- an interrupt-clear write;
- a node-ID strobe.

The bench forces each of these coincidences on its own reset edge. In every case the reset must win: the transmitter stays off, the flag stays set, and the ID is neither captured nor marked valid. A behavioural model then runs alongside the design under a long random stream in which such collisions happen often, and every output is compared on every clock.

// File: rtl/lnk_rst_pkg.sv
// Package: register offsets and control-bit positions shared by the
// bus-reset gating block, its checker and anything that writes it.
package lnk_rst_pkg;
    localparam int REG_W  = 2;  // register offset width
    localparam int NREG   = 3;  // decoded registers (offset 3 is a hole)

    typedef enum logic [REG_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_BUSNUM = 2'd1,
        REG_IRQ    = 2'd2,
        REG_HOLE   = 2'd3
    } reg_sel_e;

    localparam int CTRL_TX_BIT = 0;
    localparam int CTRL_RX_BIT = 1;
    localparam int IRQ_CLR_BIT = 0;
endpackage

// File: rtl/lnk_rst_detect.sv
// Module: lnk_rst_detect
// Turns the PHY's bus-reset level into a one-cycle start pulse.
// Assumes bus_rst_act_i is already synchronous to clk.
module lnk_rst_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_act_i,
    output logic rst_rise_o
);
    logic act_q;

    // Remember last cycle's reset level.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= bus_rst_act_i;
    end

    // A start is high now and low one cycle ago.
    assign rst_rise_o = bus_rst_act_i & ~act_q;
endmodule

// File: rtl/lnk_rst_txrx.sv
// Module: lnk_rst_txrx
// Holds the transmit and receive enables. The transmitter is forced
// off in every cycle where a bus reset is active, and only software
// can turn it back on. The receiver follows software alone.
module lnk_rst_txrx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst_act_i,
    input  logic       ctrl_wr_i,
    input  logic [1:0] ctrl_bits_i,
    output logic       tx_en_o,
    output logic       rx_en_o
);
    import lnk_rst_pkg::*;

    // Transmit enable: reset forces it off; a write may set it only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)             tx_en_o <= 1'b0;
        else if (bus_rst_act_i) tx_en_o <= 1'b0;
        else if (ctrl_wr_i)     tx_en_o <= ctrl_bits_i[CTRL_TX_BIT];
    end

    // Receive enable: written by software only; bus reset leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_en_o <= 1'b0;
        else if (ctrl_wr_i) rx_en_o <= ctrl_bits_i[CTRL_RX_BIT];
    end
endmodule

// File: rtl/lnk_rst_nodeid.sv
// Module: lnk_rst_nodeid
// Node ID register: the software-written bus number sits in the upper
// field, and the PHY-reported physical ID sits in the lower field.
// Also holds the flag that says the ID is valid. PHY reports that
// arrive during an active reset are dropped.
module lnk_rst_nodeid #(
    parameter int                 BUS_W   = 10,
    parameter int                 PHY_W   = 6,
    parameter logic [BUS_W-1:0]   BUS_RST = '1,
    parameter logic [PHY_W-1:0]   PHY_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst_act_i,
    input  logic               rst_rise_i,
    input  logic               node_id_vld_i,
    input  logic [PHY_W-1:0]   phy_id_i,
    input  logic               bus_wr_i,
    input  logic [BUS_W-1:0]   bus_num_i,
    output logic [BUS_W+PHY_W-1:0] node_id_o,
    output logic               id_vld_o
);
    logic [BUS_W-1:0] bus_q;
    logic [PHY_W-1:0] phy_q;
    logic             take_id;

    // A PHY report counts only outside an active reset.
    assign take_id = node_id_vld_i & ~bus_rst_act_i;

    // Bus number field: software owned.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_q <= BUS_RST;
        else if (bus_wr_i) bus_q <= bus_num_i;
    end

    // Physical ID field: loaded from the PHY report.
    always_ff @(posedge clk) begin
        if (!rst_n)       phy_q <= PHY_RST;
        else if (take_id) phy_q <= phy_id_i;
    end

    // Valid flag: cleared at reset start, set on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)          id_vld_o <= 1'b0;
        else if (rst_rise_i) id_vld_o <= 1'b0;
        else if (take_id)    id_vld_o <= 1'b1;
    end

    assign node_id_o = {bus_q, phy_q};
endmodule

// File: rtl/lnk_rst_irq.sv
// Module: lnk_rst_irq
// Bus-reset interrupt flag. A reset start sets it, and software clears
// it by writing 1. If both happen in the same cycle, the set wins.
module lnk_rst_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_rise_i,
    input  logic clr_wr_i,
    input  logic clr_bit_i,
    output logic irq_o
);
    // Flag with set priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     irq_o <= 1'b0;
        else if (rst_rise_i)            irq_o <= 1'b1;
        else if (clr_wr_i && clr_bit_i) irq_o <= 1'b0;
    end
endmodule

// File: rtl/lnk_rst_gate.sv
// Module: lnk_rst_gate (top)
// Bus-reset transmit gating controller for a serial-bus link layer.
// It decodes the register writes, detects the start of a reset, and
// connects the enable, node ID and interrupt submodules.
// Assumes all inputs are synchronous to clk, and BUS_W >= 2 so the
// control bits fit in the write data.
module lnk_rst_gate #(
    parameter int BUS_W = 10,
    parameter int PHY_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_rst_act_i,
    input  logic                   node_id_vld_i,
    input  logic [PHY_W-1:0]       phy_id_i,
    input  logic                   reg_wr_i,
    input  logic [1:0]             reg_addr_i,
    input  logic [BUS_W-1:0]       reg_wdata_i,
    output logic                   tx_en_o,
    output logic                   rx_en_o,
    output logic [BUS_W+PHY_W-1:0] node_id_o,
    output logic                   id_vld_o,
    output logic                   irq_o
);
    import lnk_rst_pkg::*;

    logic [NREG-1:0] wr_sel;
    logic            rst_rise;

    // One write strobe per decoded register; offset 3 decodes to nothing.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign wr_sel[g] = reg_wr_i && (reg_addr_i == REG_W'(g));
    end

    lnk_rst_detect u_det (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rst_act_i (bus_rst_act_i),
        .rst_rise_o    (rst_rise)
    );

    lnk_rst_txrx u_txrx (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rst_act_i (bus_rst_act_i),
        .ctrl_wr_i     (wr_sel[REG_CTRL]),
        .ctrl_bits_i   (reg_wdata_i[1:0]),
        .tx_en_o       (tx_en_o),
        .rx_en_o       (rx_en_o)
    );

    lnk_rst_nodeid #(.BUS_W(BUS_W), .PHY_W(PHY_W)) u_nid (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rst_act_i (bus_rst_act_i),
        .rst_rise_i    (rst_rise),
        .node_id_vld_i (node_id_vld_i),
        .phy_id_i      (phy_id_i),
        .bus_wr_i      (wr_sel[REG_BUSNUM]),
        .bus_num_i     (reg_wdata_i),
        .node_id_o     (node_id_o),
        .id_vld_o      (id_vld_o)
    );

    lnk_rst_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_rise_i (rst_rise),
        .clr_wr_i   (wr_sel[REG_IRQ]),
        .clr_bit_i  (reg_wdata_i[IRQ_CLR_BIT]),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/lnk_rst_gate_chk.sv
// Module: lnk_rst_gate_chk
// Checker for the top module's port behaviour. It is attached to
// every lnk_rst_gate instance by the bind at the end of this file.
module lnk_rst_gate_chk #(
    parameter int BUS_W = 10,
    parameter int PHY_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_rst_act_i,
    input logic                   node_id_vld_i,
    input logic [PHY_W-1:0]       phy_id_i,
    input logic                   reg_wr_i,
    input logic [1:0]             reg_addr_i,
    input logic [BUS_W-1:0]       reg_wdata_i,
    input logic                   tx_en_o,
    input logic                   rx_en_o,
    input logic [BUS_W+PHY_W-1:0] node_id_o,
    input logic                   id_vld_o,
    input logic                   irq_o
);
    // R3
    tx_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_act_i |=> !tx_en_o);

    // R4
    rx_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == 2'd0) |=> $stable(rx_en_o));

    // R6
    tx_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == 2'd0) |=> !$rose(tx_en_o));

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_act_i) |=> irq_o);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd2 && reg_wdata_i[0] && !$rose(bus_rst_act_i))
        |=> !irq_o);

    // R9
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_act_i) |=> !id_vld_o);

    // R10
    id_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (node_id_vld_i && !bus_rst_act_i)
        |=> id_vld_o && node_id_o[PHY_W-1:0] == $past(phy_id_i));

    // R11
    bus_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd1)
        |=> node_id_o[BUS_W+PHY_W-1:PHY_W] == $past(reg_wdata_i));
endmodule

bind lnk_rst_gate lnk_rst_gate_chk #(.BUS_W(BUS_W), .PHY_W(PHY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rst_act_i (bus_rst_act_i),
    .node_id_vld_i (node_id_vld_i),
    .phy_id_i      (phy_id_i),
    .reg_wr_i      (reg_wr_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .tx_en_o       (tx_en_o),
    .rx_en_o       (rx_en_o),
    .node_id_o     (node_id_o),
    .id_vld_o      (id_vld_o),
    .irq_o         (irq_o)
);

// File: tb/lnk_rst_gate_tb_top.sv
// Bench: directed checks plus a behavioural model that is compared on
// every clock. Inputs change at negedge; outputs are sampled at negedge.
module lnk_rst_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        nv = 1'b0;
    logic [5:0]  pid = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [9:0]  wd = '0;
    logic        tx, rx, vld, irq;
    logic [15:0] nid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit model_on = 0;

    // behavioural reference state
    bit       m_prev, m_tx, m_rx, m_irq, m_vld;
    bit [9:0] m_bus;
    bit [5:0] m_phy;

    always #5 clk = ~clk;

    lnk_rst_gate dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst_act_i(bus_rst),
        .node_id_vld_i(nv), .phy_id_i(pid), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wd), .tx_en_o(tx), .rx_en_o(rx),
        .node_id_o(nid), .id_vld_o(vld), .irq_o(irq)
    );

    // model update at each edge, from the inputs driven half a cycle before
    always @(posedge clk) begin
        bit rise;
        if (!rst_n) begin
            m_prev = 0; m_tx = 0; m_rx = 0; m_irq = 0; m_vld = 0;
            m_bus = 10'h3FF; m_phy = 6'h3F;
        end else begin
            rise = bus_rst && !m_prev;
            m_prev = bus_rst;
            if (wr && addr == 2'd0) begin
                m_rx = wd[1];
                m_tx = wd[0] && !bus_rst;
            end else if (bus_rst) m_tx = 0;
            if (rise) m_irq = 1;
            else if (wr && addr == 2'd2 && wd[0]) m_irq = 0;
            if (wr && addr == 2'd1) m_bus = wd;
            if (rise) m_vld = 0;
            else if (nv && !bus_rst) begin m_vld = 1; m_phy = pid; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R3 tx_en vs model", int'(tx), int'(m_tx));
            chk("R4 rx_en vs model", int'(rx), int'(m_rx));
            chk("R7 irq vs model", int'(irq), int'(m_irq));
            chk("R9 id_vld vs model", int'(vld), int'(m_vld));
            chk("R10 node_id vs model", int'(nid), int'({m_bus, m_phy}));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write(input logic [1:0] a, input logic [9:0] d);
        wr = 1; addr = a; wd = d; tick(); wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1; model_on = 1;
        tick();
        // R1 reset state
        chk("R1 tx", int'(tx), 0); chk("R1 rx", int'(rx), 0);
        chk("R1 irq", int'(irq), 0); chk("R1 vld", int'(vld), 0);
        chk("R1 node_id", int'(nid), 16'hFFFF);
        // R2 enables written while idle
        write(2'd0, 10'd3);
        chk("R2 tx", int'(tx), 1); chk("R2 rx", int'(rx), 1);
        // R11 bus number
        write(2'd1, 10'h155);
        chk("R11 node_id", int'(nid), int'({10'h155, 6'h3F}));
        // capture once so that R9 has something to clear
        nv = 1; pid = 6'h07; tick(); nv = 0;
        chk("R10 first capture", int'(vld), 1);
        // bus reset starts
        bus_rst = 1; tick();
        chk("R3 tx off", int'(tx), 0); chk("R4 rx kept", int'(rx), 1);
        chk("R7 irq set", int'(irq), 1); chk("R9 vld cleared", int'(vld), 0);
        // R5 enable attempt during reset, with rx cleared by the same write
        write(2'd0, 10'd1);
        chk("R5 tx ignored", int'(tx), 0); chk("R5 rx applied", int'(rx), 0);
        write(2'd0, 10'd3);
        chk("R5 tx still ignored", int'(tx), 0); chk("R5 rx back", int'(rx), 1);
        // R10 strobe during reset is dropped
        nv = 1; pid = 6'h2A; tick(); nv = 0;
        chk("R10 ignored id", int'(nid), int'({10'h155, 6'h07}));
        chk("R10 ignored vld", int'(vld), 0);
        // R7 clear while reset held: no re-set
        write(2'd2, 10'd1); tick(); tick();
        chk("R7 set once", int'(irq), 0);
        bus_rst = 0; repeat (5) tick();
        chk("R6 no rearm", int'(tx), 0);
        nv = 1; pid = 6'h12; tick(); nv = 0;
        chk("R10 capture id", int'(nid), int'({10'h155, 6'h12}));
        chk("R10 capture vld", int'(vld), 1);
        // R12 hole write, R8 write of 0
        bus_rst = 1; tick(); bus_rst = 0; tick();
        write(2'd3, 10'h3FF);
        chk("R12 tx", int'(tx), 0); chk("R12 rx", int'(rx), 1);
        chk("R12 id", int'(nid), int'({10'h155, 6'h12}));
        write(2'd2, 10'd0);
        chk("R8 zero write keeps", int'(irq), 1);
        write(2'd2, 10'd1);
        chk("R8 clear", int'(irq), 0);
        write(2'd0, 10'd3);
        chk("R6 sw enable", int'(tx), 1);
        // collisions with a reset start
        bus_rst = 1; wr = 1; addr = 2'd2; wd = 10'd1; tick(); wr = 0; bus_rst = 0;
        chk("R8 set wins", int'(irq), 1);
        tick(); write(2'd2, 10'd1);
        bus_rst = 1; wr = 1; addr = 2'd0; wd = 10'd3; tick(); wr = 0; bus_rst = 0;
        chk("R5 collide tx", int'(tx), 0);
        tick(); nv = 1; pid = 6'h01;
        bus_rst = 1; tick(); nv = 0; bus_rst = 0;
        chk("R10 collide vld", int'(vld), 0);
        chk("R10 collide id", int'(nid[5:0]), 6'h12);
        // random phase, judged by the model
        for (int i = 0; i < 2000; i++) begin
            bus_rst = ($urandom_range(0, 3) == 0) ? ~bus_rst : bus_rst;
            nv   = ($urandom_range(0, 4) == 0);
            pid  = 6'($urandom);
            wr   = ($urandom_range(0, 2) == 0);
            addr = 2'($urandom);
            wd   = 10'($urandom);
            tick();
        end
        wr = 0; nv = 0; bus_rst = 0; tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule